// File: doc/BRIEF.md
# Global Configuration Register Bank

This block holds the chip-wide configuration registers that a host reaches through an index/data port pair. The host first loads an 8-bit register number into the index register. It then reads or writes the chosen register through the data port. Data-port access works only while the configuration-mode input is high. The index register still loads at any time, so it is ready when configuration mode starts.

The bank contains three registers:

- **Control register** at index 0x02. It is write-only. Writing a 1 in bit 0 raises a one-cycle soft-reset pulse. The same write returns the other registers to their soft-reset values.
- **Port-select register** at index 0x03. Its two low bits choose the run-mode general-purpose index port address. Its top bit lets the watchdog and SMI registers be reached outside configuration mode.
- **Device-number register** at index 0x07. It is 8 bits wide and names the logical device that later configuration accesses address.

The control and status pins are plain level signals. Every index and data strobe is accepted in the cycle it is high, so the block needs no valid/ready handshake and never applies back-pressure.

Top module: `cfg_global_regs`

## Requirements
- R1: After the hardware reset input (rst_n low), index 0x03 reads 0x03, gp_port_addr is 0xEA, wdt_smi_run_en is 0, ldn is 0x00 and soft_rst_pulse is 0.
- R2: Register selection compares all 8 index bits, so an index such as 0x83 or 0x87 reaches no register. It reads 0x00, and a write to it changes nothing.
- R3: Indices 0x00, 0x01 and 0x04 to 0x06, and every index from 0x08 to 0xFF, read 0x00. Writes to them change no output.
- R4: In index 0x03, only bit 7 and bits 1:0 are stored. Bits 6:2 always read 0, whatever value was written.
- R5: gp_port_addr follows bits 1:0 of index 0x03: 2'b11 gives 0xEA, 2'b10 gives 0xE4, 2'b01 gives 0xE2 and 2'b00 gives 0xE0.
- R6: wdt_smi_run_en equals bit 7 of index 0x03. A 1 grants watchdog/SMI access outside configuration mode.
- R7: Index 0x07 stores all 8 written bits. It reads them back, drives them on ldn, and holds them until the next write or reset.
- R8: While cfg_mode is 0, data-port writes are ignored and dat_rdata is 0x00. Index writes still take effect.
- R9: A write to index 0x02 with bit 0 set raises soft_rst_pulse for exactly the one cycle after the write edge. At that same edge, index 0x03 returns to 0x03 and index 0x07 returns to 0x00. A write to index 0x02 with bit 0 clear has no effect.
- R10: Index 0x02 always reads 0x00.
- R11: A data write updates the addressed register and its outputs at the clock edge where dat_we is sampled high. Reads are combinational from the latched index. A data strobe uses the index that was latched before its edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| cfg_mode | input | 1 | High while configuration mode is active |
| idx_we | input | 1 | Index-port write strobe |
| idx_wdata | input | 8 | Register number to latch |
| dat_we | input | 1 | Data-port write strobe |
| dat_wdata | input | 8 | Data-port write value |
| dat_rdata | output | 8 | Data-port read value for the latched index |
| soft_rst_pulse | output | 1 | One-cycle soft-reset strobe |
| gp_port_addr | output | 8 | Decoded run-mode general-purpose index port address |
| wdt_smi_run_en | output | 1 | Watchdog/SMI access enable outside configuration mode |
| ldn | output | 8 | Current logical device number |

## Verification
An index or data write takes effect at the first rising edge that samples its strobe. So gp_port_addr, wdt_smi_run_en and ldn show the new value from that edge on. soft_rst_pulse is high only in the cycle after that edge, and dat_rdata follows the latched index with no added register. The bench changes inputs on falling edges and samples one falling edge after the strobe, which places each check half a cycle after the edge that should have changed the result. The pulse is checked at that point and again one cycle later, to confirm it lasts exactly one cycle.

// File: rtl/cfgreg_pkg.sv
package cfgreg_pkg;
  localparam int CFG_DW = 8;

  // register numbers, fully decoded
  localparam logic [7:0] IDX_CTL   = 8'h02;
  localparam logic [7:0] IDX_PSEL  = 8'h03;
  localparam logic [7:0] IDX_LDN   = 8'h07;

  // storage masks and soft/hard reset values
  localparam logic [7:0] PSEL_MASK = 8'h83;
  localparam logic [7:0] PSEL_INIT = 8'h03;
  localparam logic [7:0] LDN_INIT  = 8'h00;

  typedef struct packed {
    logic ctl;
    logic psel;
    logic ldn;
  } wsel_t;

  function automatic logic [7:0] port_addr_of(input logic [1:0] code);
    case (code)
      2'b11:   port_addr_of = 8'hEA;
      2'b10:   port_addr_of = 8'hE4;
      2'b01:   port_addr_of = 8'hE2;
      default: port_addr_of = 8'hE0;
    endcase
  endfunction
endpackage

// File: rtl/cfgreg_index_latch.sv
module cfgreg_index_latch #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idx_we,
  input  logic [DW-1:0] idx_wdata,
  output logic [DW-1:0] idx_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_we) idx_q <= idx_wdata;
  end
endmodule

// File: rtl/cfgreg_decode.sv
module cfgreg_decode
  import cfgreg_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_mode,
  input  logic          dat_we,
  input  logic [DW-1:0] idx_q,
  input  logic [DW-1:0] psel_q,
  input  logic [DW-1:0] ldn_q,
  output wsel_t         wsel,
  output logic [DW-1:0] rdata
);
  logic hit_ctl, hit_psel, hit_ldn;

  always_comb begin
    hit_ctl  = (idx_q == DW'(IDX_CTL));
    hit_psel = (idx_q == DW'(IDX_PSEL));
    hit_ldn  = (idx_q == DW'(IDX_LDN));
  end

  always_comb begin
    wsel.ctl  = cfg_mode && dat_we && hit_ctl;
    wsel.psel = cfg_mode && dat_we && hit_psel;
    wsel.ldn  = cfg_mode && dat_we && hit_ldn;
  end

  always_comb begin
    rdata = '0;
    if (cfg_mode) begin
      if (hit_psel)     rdata = psel_q;
      else if (hit_ldn) rdata = ldn_q;
    end
  end

  AST_WSEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wsel)); // R2
  AST_CTL_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_q == DW'(IDX_CTL)) |-> (rdata == '0)); // R10
  AST_OUT_OF_CFG_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode |-> (rdata == '0)); // R8
  AST_PSEL_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode && idx_q == DW'(IDX_PSEL)) |-> (rdata[6:2] == 5'd0)); // R4
endmodule

// File: rtl/cfgreg_store.sv
module cfgreg_store
  import cfgreg_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  wsel_t         wsel,
  input  logic [DW-1:0] wdata,
  output logic          soft_now,
  output logic [DW-1:0] psel_q,
  output logic [DW-1:0] ldn_q
);
  localparam logic [DW-1:0] PMASK = DW'(PSEL_MASK);

  always_comb soft_now = wsel.ctl && wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         psel_q <= DW'(PSEL_INIT);
    else if (soft_now)  psel_q <= DW'(PSEL_INIT);
    else if (wsel.psel) psel_q <= wdata & PMASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ldn_q <= DW'(LDN_INIT);
    else if (soft_now) ldn_q <= DW'(LDN_INIT);
    else if (wsel.ldn) ldn_q <= wdata;
  end

  AST_LDN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wsel.ldn && !soft_now) |=> $stable(ldn_q)); // R7
  AST_SOFT_RESTORES_PSEL: assert property (@(posedge clk) disable iff (!rst_n)
    soft_now |=> (psel_q == DW'(PSEL_INIT))); // R9
endmodule

// File: rtl/cfgreg_softrst.sv
module cfgreg_softrst (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= fire;
  end
endmodule

// File: rtl/cfg_global_regs.sv
module cfg_global_regs
  import cfgreg_pkg::*;
#(
  parameter int DW = CFG_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_mode,
  input  logic          idx_we,
  input  logic [DW-1:0] idx_wdata,
  input  logic          dat_we,
  input  logic [DW-1:0] dat_wdata,
  output logic [DW-1:0] dat_rdata,
  output logic          soft_rst_pulse,
  output logic [7:0]    gp_port_addr,
  output logic          wdt_smi_run_en,
  output logic [DW-1:0] ldn
);
  logic [DW-1:0] idx_q, psel_q, ldn_q;
  wsel_t         wsel;
  logic          soft_now;

  cfgreg_index_latch #(.DW(DW)) u_idx (
    .clk(clk), .rst_n(rst_n), .idx_we(idx_we), .idx_wdata(idx_wdata), .idx_q(idx_q));

  cfgreg_decode #(.DW(DW)) u_dec (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .dat_we(dat_we), .idx_q(idx_q),
    .psel_q(psel_q), .ldn_q(ldn_q), .wsel(wsel), .rdata(dat_rdata));

  cfgreg_store #(.DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .wsel(wsel), .wdata(dat_wdata),
    .soft_now(soft_now), .psel_q(psel_q), .ldn_q(ldn_q));

  cfgreg_softrst u_soft (
    .clk(clk), .rst_n(rst_n), .fire(soft_now), .pulse_q(soft_rst_pulse));

  always_comb begin
    gp_port_addr   = port_addr_of(psel_q[1:0]);
    wdt_smi_run_en = psel_q[7];
    ldn            = ldn_q;
  end

  AST_GP_ADDR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    gp_port_addr inside {8'hE0, 8'hE2, 8'hE4, 8'hEA}); // R5
  AST_PULSE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_pulse |-> (ldn == '0 && gp_port_addr == 8'hEA && !wdt_smi_run_en)); // R9
  AST_NO_WRITE_OUTSIDE_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode |=> ($stable(ldn) && $stable(gp_port_addr) && $stable(wdt_smi_run_en))); // R8
endmodule

// File: tb/test_cfg_global_regs.sv
module test_cfg_global_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_mode = 1'b0;
  logic       idx_we = 1'b0;
  logic [7:0] idx_wdata = '0;
  logic       dat_we = 1'b0;
  logic [7:0] dat_wdata = '0;
  logic [7:0] dat_rdata, gp_port_addr, ldn;
  logic       soft_rst_pulse, wdt_smi_run_en;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  cfg_global_regs i_cfg_global_regs (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .idx_we(idx_we), .idx_wdata(idx_wdata),
    .dat_we(dat_we), .dat_wdata(dat_wdata), .dat_rdata(dat_rdata),
    .soft_rst_pulse(soft_rst_pulse), .gp_port_addr(gp_port_addr),
    .wdt_smi_run_en(wdt_smi_run_en), .ldn(ldn));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic put_idx(input logic [7:0] i);
    @(negedge clk); idx_we = 1'b1; idx_wdata = i;
    @(negedge clk); idx_we = 1'b0;
  endtask

  task automatic put_dat(input logic [7:0] v);
    @(negedge clk); dat_we = 1'b1; dat_wdata = v;
    @(negedge clk); dat_we = 1'b0;
  endtask

  task automatic wr(input logic [7:0] i, input logic [7:0] v);
    put_idx(i); put_dat(v);
  endtask

  task automatic rd(input logic [7:0] i, output logic [7:0] v);
    put_idx(i); #1 v = dat_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 pulse", {7'd0, soft_rst_pulse}, 8'h00);
    chk("R1 gp_port_addr", gp_port_addr, 8'hEA);
    chk("R1 wdt_en", {7'd0, wdt_smi_run_en}, 8'h00);
    chk("R1 ldn", ldn, 8'h00);
    cfg_mode = 1'b1;
    rd(8'h03, v); chk("R1 idx03 read", v, 8'h03);
  endtask

  task automatic t_port_select;
    logic [7:0] v;
    logic [7:0] exp_addr [4] = '{8'hE0, 8'hE2, 8'hE4, 8'hEA};
    for (int c = 0; c < 4; c++) begin
      wr(8'h03, 8'h7C | 8'(c));
      // R11: output updated at the write edge, sampled half a cycle later
      chk("R5 gp_port_addr", gp_port_addr, exp_addr[c]);
      chk("R11 wdt_en stays 0", {7'd0, wdt_smi_run_en}, 8'h00);
      #1 chk("R4 idx03 read", dat_rdata, 8'(c));
    end
    wr(8'h03, 8'hFE);
    chk("R6 wdt_en set", {7'd0, wdt_smi_run_en}, 8'h01);
    chk("R5 gp after FE", gp_port_addr, 8'hE4);
    rd(8'h03, v); chk("R4 idx03 read FE", v, 8'h82);
    wr(8'h03, 8'h01);
    chk("R6 wdt_en clear", {7'd0, wdt_smi_run_en}, 8'h00);
  endtask

  task automatic t_ldn;
    logic [7:0] v;
    wr(8'h07, 8'hA5); chk("R7 ldn out", ldn, 8'hA5);
    rd(8'h07, v); chk("R7 ldn read", v, 8'hA5);
    wr(8'h07, 8'h5A); chk("R7 ldn out 2", ldn, 8'h5A);
    repeat (3) @(negedge clk);
    chk("R7 ldn holds", ldn, 8'h5A);
  endtask

  task automatic t_reserved;
    logic [7:0] v;
    logic [7:0] holes [6] = '{8'h00, 8'h01, 8'h04, 8'h05, 8'h06, 8'h2F};
    foreach (holes[k]) begin
      wr(holes[k], 8'hFF);
      #1 chk("R3 hole read", dat_rdata, 8'h00);
      chk("R3 ldn untouched", ldn, 8'h5A);
      chk("R3 gp untouched", gp_port_addr, 8'hE2);
    end
    wr(8'h83, 8'h80);
    #1 chk("R2 0x83 read", dat_rdata, 8'h00);
    chk("R2 0x83 no alias", {7'd0, wdt_smi_run_en}, 8'h00);
    wr(8'h87, 8'h11);
    chk("R2 0x87 no alias", ldn, 8'h5A);
    rd(8'hFF, v); chk("R3 0xFF read", v, 8'h00);
  endtask

  task automatic t_outside_cfg;
    cfg_mode = 1'b0;
    put_idx(8'h07);
    #1 chk("R8 read zero", dat_rdata, 8'h00);
    put_dat(8'h33);
    chk("R8 ldn ignored", ldn, 8'h5A);
    cfg_mode = 1'b1;
    #1 chk("R8 index latched outside", dat_rdata, 8'h5A);
    cfg_mode = 1'b0;
    put_idx(8'h02); put_dat(8'h01);
    chk("R8 no soft reset outside", {7'd0, soft_rst_pulse}, 8'h00);
    cfg_mode = 1'b1;
  endtask

  task automatic t_soft;
    logic [7:0] v;
    wr(8'h03, 8'h80);
    wr(8'h02, 8'hFE);
    chk("R9 bit0 clear no pulse", {7'd0, soft_rst_pulse}, 8'h00);
    chk("R9 bit0 clear keeps ldn", ldn, 8'h5A);
    #1 chk("R10 ctl reads zero", dat_rdata, 8'h00);
    put_dat(8'h01);
    chk("R9 pulse high", {7'd0, soft_rst_pulse}, 8'h01);
    chk("R9 ldn restored", ldn, 8'h00);
    chk("R9 gp restored", gp_port_addr, 8'hEA);
    chk("R9 wdt_en cleared", {7'd0, wdt_smi_run_en}, 8'h00);
    @(negedge clk);
    chk("R9 pulse one cycle", {7'd0, soft_rst_pulse}, 8'h00);
    rd(8'h03, v); chk("R9 idx03 soft value", v, 8'h03);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_port_select();
        t_ldn();
        t_reserved();
        t_outside_cfg();
        t_soft();
      end
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule